// File: doc/BRIEF.md
# Descriptor-Driven Scatter-Gather DMA Engine

This block moves a storage command's data between a local sector buffer and host memory. Software leaves a list of 8-byte region descriptors in memory. Each descriptor gives a region address, a byte count and a last-entry flag. The engine fetches the descriptors one at a time over a request/grant memory master port and copies each region in bursts. No burst crosses a page boundary. The engine counts sectors and remaining bytes, and it tells the device engine when the list is finished.

The host supplies the list base address and a start level. The device engine supplies the transfer direction, the total byte count of the command and the first sector number. It also supplies a flag that says the device has entered its DMA data phase. If the memory side reports busy at the moment a request would be issued, the engine waits a fixed number of cycles and then tries the same step again. Dropping the start level during a transfer abandons the command and reports an abort.

Top module: `prd_dma_engine`

## Requirements
- R1: After reset no request, done, abort or length error is asserted. A transfer begins only on a rising edge of `start_i` seen while `dev_dma_ready_i` is high. A start level that is already high when the device becomes ready starts nothing.
- R2: The descriptor pointer is `table_base_i` with bits 1:0 forced to zero. Each descriptor fetch is a read (`mem_we_o`=0) of length 8 at that pointer. The pointer then advances by 8 for the next descriptor.
- R3: A granted descriptor read returns two words on `mem_rdata_i`. Bits 31:0 hold the region address. Bits 47:32 hold the region byte count, where 0 means 65536 bytes. Bit 63 is the end-of-list flag.
- R4: Each burst has length min(bytes left in region, PAGE_BYTES minus the address offset in the page), so no burst crosses a page. The bursts of a region are issued in address order. `mem_buf_off_o` carries the bytes already moved in that region.
- R5: When `to_mem_i`=1 (the device sends data to memory) the region bursts are writes (`mem_we_o`=1). When `to_mem_i`=0 they are reads.
- R6: If `mem_busy_i` is high when a request would be issued, no request is raised. The engine waits BACKOFF_CYCLES cycles and then repeats the same step with the same address.
- R7: After a region completes, `sector_o` rises by the region count divided by SECTOR_BYTES, and `bytes_left_o` drops by the region count.
- R8: After a region with the end-of-list flag, `done_o` pulses for one cycle. `len_err_o` is asserted in that same cycle exactly when `bytes_left_o` is then nonzero. Without the flag, the next descriptor is fetched.
- R9: If `start_i` falls while a transfer is active, `abort_o` pulses for one cycle, `mem_req_o` is low in that cycle, and no `done_o` follows.
- R10: A request is held, with address, length and direction unchanged, until the cycle in which `mem_gnt_i` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Host start level; rising edge begins, falling edge aborts |
| table_base_i | input | 32 | Descriptor list base address |
| dev_dma_ready_i | input | 1 | Device is in its DMA data phase |
| to_mem_i | input | 1 | 1: device-to-memory, 0: memory-to-device |
| xfer_bytes_i | input | XFER_W | Total bytes of the command |
| sector_i | input | SECTOR_W | First sector number |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | Request is a write to memory |
| mem_addr_o | output | 32 | Request address |
| mem_len_o | output | LEN_W | Request length in bytes |
| mem_buf_off_o | output | 17 | Sector buffer offset for the burst |
| mem_busy_i | input | 1 | Memory port cannot take a request now |
| mem_gnt_i | input | 1 | Request accepted and completed this cycle |
| mem_rdata_i | input | 64 | Descriptor read data, valid with grant |
| done_o | output | 1 | One-cycle pulse: list finished |
| abort_o | output | 1 | One-cycle pulse: command abandoned |
| len_err_o | output | 1 | With done: byte count left nonzero |
| sector_o | output | SECTOR_W | Current sector number |
| bytes_left_o | output | XFER_W | Remaining bytes of the command |

## Verification
The bench builds the engine with a 64-byte page, 16-byte sectors and a 5-cycle back-off. With these values, short regions cross several page boundaries, and a single 65536-byte descriptor produces 1024 bursts in a few thousand cycles. Short windows of busy and slow grants also reach both retry points and the held-request path. The list base is given unaligned to exercise the forced-zero low bits.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;

    localparam int DESC_BYTES = 8;
    localparam int REGION_W   = 17;
    localparam int LAST_BIT   = 63;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_DESC_ISSUE = 3'd1,
        ST_DESC_WAIT  = 3'd2,
        ST_DATA_ISSUE = 3'd3,
        ST_DATA_WAIT  = 3'd4,
        ST_REGION_END = 3'd5,
        ST_BACKOFF    = 3'd6
    } eng_state_e;

    typedef struct packed {
        logic [31:0]         base;
        logic [REGION_W-1:0] bytes;
        logic                last;
    } region_t;

endpackage

// File: rtl/prd_desc_unpack.sv
module prd_desc_unpack
    import prd_dma_pkg::*;
(
    input  logic [63:0] raw_i,
    output region_t     region_o
);
    logic [15:0] cnt;
    logic        rsvd_unused;

    assign cnt         = raw_i[47:32];
    assign rsvd_unused = ^raw_i[62:48];

    always_comb begin
        region_o.base  = raw_i[31:0];
        region_o.bytes = (cnt == 16'd0) ? REGION_W'(65536) : REGION_W'(cnt);
        region_o.last  = raw_i[LAST_BIT];
    end
endmodule

// File: rtl/prd_chunk_calc.sv
module prd_chunk_calc
    import prd_dma_pkg::*;
#(
    parameter int PAGE_BYTES = 4096,
    localparam int PG_W      = $clog2(PAGE_BYTES),
    localparam int LEN_W     = PG_W + 1
) (
    input  logic [PG_W-1:0]     page_off_i,
    input  logic [REGION_W-1:0] left_i,
    output logic [LEN_W-1:0]    len_o
);
    logic [REGION_W-1:0] room;

    always_comb begin
        room = REGION_W'(PAGE_BYTES) - REGION_W'(page_off_i);
        if (left_i < room) len_o = LEN_W'(left_i);
        else               len_o = LEN_W'(room);
    end
endmodule

// File: rtl/prd_backoff_timer.sv
module prd_backoff_timer #(
    parameter int CYCLES = 16,
    localparam int CNT_W = $clog2(CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)              cnt_d = CNT_W'(CYCLES - 1);
        else if (cnt_q != '0)    cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
    import prd_dma_pkg::*;
#(
    parameter int PAGE_BYTES     = 4096,
    parameter int SECTOR_BYTES   = 512,
    parameter int BACKOFF_CYCLES = 16,
    parameter int XFER_W         = 18,
    parameter int SECTOR_W       = 32,
    localparam int PG_W          = $clog2(PAGE_BYTES),
    localparam int LEN_W         = PG_W + 1,
    localparam int SEC_SH        = $clog2(SECTOR_BYTES)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [31:0]         table_base_i,
    input  logic                dev_dma_ready_i,
    input  logic                to_mem_i,
    input  logic [XFER_W-1:0]   xfer_bytes_i,
    input  logic [SECTOR_W-1:0] sector_i,
    output logic                mem_req_o,
    output logic                mem_we_o,
    output logic [31:0]         mem_addr_o,
    output logic [LEN_W-1:0]    mem_len_o,
    output logic [REGION_W-1:0] mem_buf_off_o,
    input  logic                mem_busy_i,
    input  logic                mem_gnt_i,
    input  logic [63:0]         mem_rdata_i,
    output logic                done_o,
    output logic                abort_o,
    output logic                len_err_o,
    output logic [SECTOR_W-1:0] sector_o,
    output logic [XFER_W-1:0]   bytes_left_o
);

    typedef struct packed {
        eng_state_e          st;
        eng_state_e          resume;
        logic                start_seen;
        logic                to_mem;
        logic [31:0]         tbl_ptr;
        logic [31:0]         rgn_addr;
        logic [REGION_W-1:0] rgn_left;
        logic [REGION_W-1:0] rgn_total;
        logic [REGION_W-1:0] buf_off;
        logic                last;
        logic [XFER_W-1:0]   left;
        logic [SECTOR_W-1:0] sector;
        logic                done;
        logic                abort;
        logic                len_err;
    } eng_regs_t;

    eng_regs_t           regs_d, regs_q;
    region_t             fetched;
    logic [LEN_W-1:0]    chunk_len;
    logic                bo_load;
    logic                bo_expired;
    logic                fetch_desc;
    logic                move_data;
    logic [XFER_W-1:0]   left_after;

    prd_desc_unpack u_unpack (
        .raw_i    (mem_rdata_i),
        .region_o (fetched)
    );

    prd_chunk_calc #(
        .PAGE_BYTES (PAGE_BYTES)
    ) u_chunk (
        .page_off_i (regs_q.rgn_addr[PG_W-1:0]),
        .left_i     (regs_q.rgn_left),
        .len_o      (chunk_len)
    );

    prd_backoff_timer #(
        .CYCLES (BACKOFF_CYCLES)
    ) u_backoff (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (bo_load),
        .expired_o (bo_expired)
    );

    assign fetch_desc = (regs_q.st == ST_DESC_WAIT);
    assign move_data  = (regs_q.st == ST_DATA_WAIT);
    assign left_after = regs_q.left - XFER_W'(regs_q.rgn_total);

    always_comb begin
        regs_d            = regs_q;
        regs_d.done       = 1'b0;
        regs_d.abort      = 1'b0;
        regs_d.len_err    = 1'b0;
        regs_d.start_seen = start_i;
        bo_load           = 1'b0;

        if (regs_q.st != ST_IDLE && !start_i) begin
            regs_d.st    = ST_IDLE;
            regs_d.abort = 1'b1;
        end else begin
            unique case (regs_q.st)
                ST_IDLE: begin
                    if (start_i && !regs_q.start_seen && dev_dma_ready_i) begin
                        regs_d.tbl_ptr = table_base_i & ~32'h3;
                        regs_d.left    = xfer_bytes_i;
                        regs_d.sector  = sector_i;
                        regs_d.to_mem  = to_mem_i;
                        regs_d.st      = ST_DESC_ISSUE;
                    end
                end
                ST_DESC_ISSUE: begin
                    if (mem_busy_i) begin
                        bo_load       = 1'b1;
                        regs_d.resume = ST_DESC_ISSUE;
                        regs_d.st     = ST_BACKOFF;
                    end else begin
                        regs_d.st = ST_DESC_WAIT;
                    end
                end
                ST_DESC_WAIT: begin
                    if (mem_gnt_i) begin
                        regs_d.rgn_addr  = fetched.base;
                        regs_d.rgn_left  = fetched.bytes;
                        regs_d.rgn_total = fetched.bytes;
                        regs_d.last      = fetched.last;
                        regs_d.buf_off   = '0;
                        regs_d.tbl_ptr   = regs_q.tbl_ptr + 32'(DESC_BYTES);
                        regs_d.st        = ST_DATA_ISSUE;
                    end
                end
                ST_DATA_ISSUE: begin
                    if (mem_busy_i) begin
                        bo_load       = 1'b1;
                        regs_d.resume = ST_DATA_ISSUE;
                        regs_d.st     = ST_BACKOFF;
                    end else begin
                        regs_d.st = ST_DATA_WAIT;
                    end
                end
                ST_DATA_WAIT: begin
                    if (mem_gnt_i) begin
                        regs_d.rgn_addr = regs_q.rgn_addr + 32'(chunk_len);
                        regs_d.rgn_left = regs_q.rgn_left - REGION_W'(chunk_len);
                        regs_d.buf_off  = regs_q.buf_off + REGION_W'(chunk_len);
                        if (REGION_W'(chunk_len) == regs_q.rgn_left)
                            regs_d.st = ST_REGION_END;
                        else
                            regs_d.st = ST_DATA_ISSUE;
                    end
                end
                ST_REGION_END: begin
                    regs_d.sector = regs_q.sector
                                  + SECTOR_W'(regs_q.rgn_total >> SEC_SH);
                    regs_d.left   = left_after;
                    if (regs_q.last) begin
                        regs_d.done    = 1'b1;
                        regs_d.len_err = (left_after != '0);
                        regs_d.st      = ST_IDLE;
                    end else begin
                        regs_d.st = ST_DESC_ISSUE;
                    end
                end
                ST_BACKOFF: begin
                    if (bo_expired) regs_d.st = regs_q.resume;
                end
                default: regs_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    assign mem_req_o     = fetch_desc || move_data;
    assign mem_we_o      = move_data && regs_q.to_mem;
    assign mem_addr_o    = fetch_desc ? regs_q.tbl_ptr : regs_q.rgn_addr;
    assign mem_len_o     = fetch_desc ? LEN_W'(DESC_BYTES) : chunk_len;
    assign mem_buf_off_o = fetch_desc ? '0 : regs_q.buf_off;
    assign done_o        = regs_q.done;
    assign abort_o       = regs_q.abort;
    assign len_err_o     = regs_q.len_err;
    assign sector_o      = regs_q.sector;
    assign bytes_left_o  = regs_q.left;

endmodule

// File: rtl/prd_dma_engine_chk.sv
module prd_dma_engine_chk #(
    parameter int PAGE_BYTES = 4096,
    parameter int LEN_W      = 13,
    localparam int PG_W      = $clog2(PAGE_BYTES)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             mem_req_o,
    input logic             mem_we_o,
    input logic [31:0]      mem_addr_o,
    input logic [LEN_W-1:0] mem_len_o,
    input logic             mem_busy_i,
    input logic             mem_gnt_i,
    input logic             is_desc,
    input logic             done_o,
    input logic             abort_o,
    input logic             len_err_o
);

    p_req_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i && start_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_len_o) && $stable(mem_we_o)));

    p_no_page_cross_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !is_desc) |->
            (int'(mem_addr_o[PG_W-1:0]) + int'(mem_len_o) <= PAGE_BYTES));

    p_desc_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && is_desc) |->
            (!mem_we_o && int'(mem_len_o) == 8 && mem_addr_o[1:0] == 2'b00));

    p_no_req_when_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_req_o) |-> !$past(mem_busy_i));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_len_err_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        len_err_o |-> done_o);

    p_end_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({done_o, abort_o}));

    p_abort_drops_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        abort_o |-> !mem_req_o);

endmodule

bind prd_dma_engine prd_dma_engine_chk #(
    .PAGE_BYTES (PAGE_BYTES),
    .LEN_W      (LEN_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mem_req_o  (mem_req_o),
    .mem_we_o   (mem_we_o),
    .mem_addr_o (mem_addr_o),
    .mem_len_o  (mem_len_o),
    .mem_busy_i (mem_busy_i),
    .mem_gnt_i  (mem_gnt_i),
    .is_desc    (fetch_desc),
    .done_o     (done_o),
    .abort_o    (abort_o),
    .len_err_o  (len_err_o)
);

// File: tb/prd_dma_engine_tb.sv
module prd_dma_engine_tb;
    localparam int PAGE  = 64;
    localparam int SECT  = 16;
    localparam int BO    = 5;
    localparam int XW    = 18;
    localparam int SW    = 32;
    localparam int LW    = $clog2(PAGE) + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [31:0]   tbl_base = '0;
    logic          dev_rdy = 1'b0;
    logic          to_mem = 1'b0;
    logic [XW-1:0] xfer = '0;
    logic [SW-1:0] sec0 = '0;
    logic          mem_req, mem_we;
    logic [31:0]   mem_addr;
    logic [LW-1:0] mem_len;
    logic [16:0]   mem_off;
    logic          mem_busy = 1'b0;
    logic          mem_gnt = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          done, abort_p, len_err;
    logic [SW-1:0] sector;
    logic [XW-1:0] bytes_left;

    int n_cmp = 0;
    int n_bad = 0;

    logic [31:0] mem_w [int unsigned];
    logic [31:0] q_addr[$];
    int          q_len[$];
    bit          q_we[$];
    int          q_off[$];

    int  gnt_lat = 0;
    int  wait_cnt = 0;
    bit  force_busy = 1'b0;
    int  busy_cnt = 0;
    int  busy_at_grant = -1;
    int  grant_count = 0;

    always #10 clk = ~clk;

    prd_dma_engine #(
        .PAGE_BYTES(PAGE), .SECTOR_BYTES(SECT), .BACKOFF_CYCLES(BO),
        .XFER_W(XW), .SECTOR_W(SW)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .table_base_i(tbl_base),
        .dev_dma_ready_i(dev_rdy), .to_mem_i(to_mem), .xfer_bytes_i(xfer),
        .sector_i(sec0), .mem_req_o(mem_req), .mem_we_o(mem_we),
        .mem_addr_o(mem_addr), .mem_len_o(mem_len), .mem_buf_off_o(mem_off),
        .mem_busy_i(mem_busy), .mem_gnt_i(mem_gnt), .mem_rdata_i(mem_rdata),
        .done_o(done), .abort_o(abort_p), .len_err_o(len_err),
        .sector_o(sector), .bytes_left_o(bytes_left)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_w.exists(a)) return mem_w[a];
        return 32'h0;
    endfunction

    task automatic put_desc(input logic [31:0] at, input logic [31:0] base,
                            input logic [15:0] cnt, input bit last);
        mem_w[at]     = base;
        mem_w[at + 4] = {last, 15'h0, cnt};
    endtask

    // Reference model: expected request stream from the descriptor list (R2, R3, R4, R5)
    task automatic build_expected(input logic [31:0] base, input bit dir, output int total);
        logic [31:0] ptr;
        total = 0;
        ptr = base & ~32'h3;
        for (int k = 0; k < 64; k++) begin
            logic [31:0] w0, w1, a;
            int cnt, left, off, room, c;
            w0 = rd(ptr); w1 = rd(ptr + 4);
            q_addr.push_back(ptr); q_len.push_back(8); q_we.push_back(1'b0); q_off.push_back(0);
            cnt = (w1[15:0] == 16'd0) ? 65536 : int'(w1[15:0]);
            a = w0; left = cnt; off = 0;
            while (left > 0) begin
                room = PAGE - int'(a % PAGE);
                c = (left < room) ? left : room;
                q_addr.push_back(a); q_len.push_back(c); q_we.push_back(dir); q_off.push_back(off);
                a += c; left -= c; off += c;
            end
            total += cnt;
            ptr += 8;
            if (w1[31]) break;
        end
    endtask

    // Memory responder: compares each granted request with the model (R10, R6)
    initial begin
        forever begin
            @(negedge clk);
            if (busy_cnt > 0) begin
                check(!mem_req, "R6", "request while busy", mem_req, 0);
                busy_cnt--;
            end
            if (mem_gnt) begin
                mem_gnt = 1'b0;
            end else if (mem_req) begin
                if (wait_cnt < gnt_lat) begin
                    wait_cnt++;
                end else begin
                    wait_cnt = 0;
                    if (q_addr.size() == 0) begin
                        check(1'b0, "R2", "unexpected request", mem_addr, 0);
                    end else begin
                        check(mem_addr == q_addr[0], "R4", "addr", mem_addr, q_addr[0]);
                        check(int'(mem_len) == q_len[0], "R4", "len", mem_len, q_len[0]);
                        check(mem_we == q_we[0], "R5", "direction", mem_we, q_we[0]);
                        check(int'(mem_off) == q_off[0], "R4", "buffer offset", mem_off, q_off[0]);
                        void'(q_addr.pop_front()); void'(q_len.pop_front());
                        void'(q_we.pop_front()); void'(q_off.pop_front());
                    end
                    mem_rdata = {rd(mem_addr + 4), rd(mem_addr)};
                    mem_gnt = 1'b1;
                    grant_count++;
                    if (grant_count == busy_at_grant) busy_cnt = 4;
                end
            end else if (wait_cnt > 0) begin
                check(1'b0, "R10", "request dropped before grant", 0, 1);
                wait_cnt = 0;
            end
            mem_busy = force_busy || (busy_cnt > 0);
        end
    end

    task automatic run_case(input string name, input logic [31:0] tb_base,
                            input int bytes, input int s0, input bit dir, input bit exp_err);
        int total, waited;
        bit seen;
        build_expected(tb_base, dir, total);
        @(negedge clk);
        tbl_base = tb_base; xfer = XW'(bytes); sec0 = SW'(s0); to_mem = dir;
        dev_rdy = 1'b1; start = 1'b1;
        seen = 1'b0;
        for (waited = 0; waited < 20000 && !seen; waited++) begin
            @(negedge clk);
            if (done) seen = 1'b1;
        end
        check(seen, "R8", {name, " done seen"}, seen, 1);
        check(len_err == exp_err, "R8", {name, " length error"}, len_err, exp_err);
        check(sector == SW'(s0 + total / SECT), "R7", {name, " sector"}, sector, s0 + total / SECT);
        check(bytes_left == XW'(bytes - total), "R7", {name, " bytes left"},
              bytes_left, XW'(bytes - total));
        check(q_addr.size() == 0, "R2", {name, " all requests issued"}, q_addr.size(), 0);
        @(negedge clk);
        check(!done, "R8", {name, " done is one pulse"}, done, 0);
        start = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(!mem_req && !done && !abort_p && !len_err, "R1", "reset outputs",
              {mem_req, done, abort_p, len_err}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: start while device not ready, then ready with start held high
        start = 1'b1; dev_rdy = 1'b0;
        begin
            bit any = 1'b0;
            for (int i = 0; i < 12; i++) begin @(negedge clk); any |= mem_req; end
            check(!any, "R1", "no request while device not ready", any, 0);
            dev_rdy = 1'b1;
            any = 1'b0;
            for (int i = 0; i < 12; i++) begin @(negedge clk); any |= mem_req; end
            check(!any, "R1", "held start does not begin", any, 0);
        end
        start = 1'b0; dev_rdy = 1'b0;
        repeat (2) @(negedge clk);

        // R5/R7/R8: one region, device-to-memory
        put_desc(32'h100, 32'h2000, 16'd48, 1'b1);
        run_case("single", 32'h100, 48, 100, 1'b1, 1'b0);

        // R2/R3/R4: unaligned base, three regions crossing pages, slow grants
        put_desc(32'h200, 32'h3030, 16'd80, 1'b0);
        put_desc(32'h208, 32'h4008, 16'd16, 1'b0);
        put_desc(32'h210, 32'h5000, 16'd112, 1'b1);
        gnt_lat = 3;
        run_case("multi", 32'h203, 208, 0, 1'b0, 1'b0);
        gnt_lat = 0;

        // R6: busy before the descriptor fetch
        put_desc(32'h300, 32'h6010, 16'd96, 1'b1);
        force_busy = 1'b1;
        @(negedge clk);
        build_expected_dummy();
        begin
            int total;
            bit any = 1'b0;
            int gap;
            build_expected(32'h300, 1'b1, total);
            tbl_base = 32'h300; xfer = XW'(96); sec0 = SW'(7); to_mem = 1'b1;
            dev_rdy = 1'b1; start = 1'b1;
            for (int i = 0; i < 20; i++) begin @(negedge clk); any |= mem_req; end
            check(!any, "R6", "no request during busy", any, 0);
            force_busy = 1'b0;
            gap = 0;
            while (!mem_req && gap < BO + 6) begin @(negedge clk); gap++; end
            check(mem_req, "R6", "retry after back-off", mem_req, 1);
            for (int i = 0; i < 200 && !done; i++) @(negedge clk);
            check(done, "R8", "busy case done", done, 1);
            check(sector == SW'(7 + 6), "R7", "busy case sector", sector, 13);
            check(q_addr.size() == 0, "R6", "busy case requests", q_addr.size(), 0);
            @(negedge clk);
            start = 1'b0;
            repeat (3) @(negedge clk);
        end

        // R6: busy after the descriptor grant, before the first burst
        put_desc(32'h400, 32'h7020, 16'd64, 1'b1);
        busy_at_grant = grant_count + 1;
        run_case("busy-data", 32'h400, 64, 20, 1'b0, 1'b0);
        busy_at_grant = -1;

        // R3: count 0 means 65536 bytes
        put_desc(32'h500, 32'h10000, 16'd0, 1'b1);
        run_case("full-64k", 32'h500, 65536, 0, 1'b1, 1'b0);

        // R8: list ends with bytes still outstanding
        put_desc(32'h600, 32'h8000, 16'd32, 1'b1);
        run_case("short-list", 32'h600, 64, 3, 1'b0, 1'b1);

        // R9: start dropped mid-transfer
        put_desc(32'h700, 32'h9000, 16'd256, 1'b1);
        begin
            int total, g0;
            bit any_done = 1'b0;
            build_expected(32'h700, 1'b1, total);
            g0 = grant_count;
            @(negedge clk);
            tbl_base = 32'h700; xfer = XW'(256); to_mem = 1'b1; dev_rdy = 1'b1; start = 1'b1;
            while (grant_count < g0 + 2) @(negedge clk);
            start = 1'b0;
            @(negedge clk);
            check(abort_p, "R9", "abort pulse", abort_p, 1);
            check(!mem_req, "R9", "request dropped on abort", mem_req, 0);
            @(negedge clk);
            check(!abort_p, "R9", "abort is one pulse", abort_p, 0);
            for (int i = 0; i < 20; i++) begin @(negedge clk); any_done |= done | mem_req; end
            check(!any_done, "R9", "no done or request after abort", any_done, 0);
            q_addr.delete(); q_len.delete(); q_we.delete(); q_off.delete();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    task automatic build_expected_dummy();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule